// File: doc/BRIEF.md
# Phase-Difference Charge Pulse Generator

This block is the digital timing front end of a phase-to-voltage converter. All of its inputs are sampled by a fast oversampling clock. A falling edge on an active-low start strobe arms the block. The block then measures the interval between the first qualifying data edge and the nearest rising edge of a slower measured clock. It turns that interval into a charge pulse when data leads, or a discharge pulse when data lags. An external charge pump integrates these pulses. While the strobe is high, the block asks the analog side to hold its output at the reference level.

A calibration mode ignores data and emits a charge and a discharge pulse whose widths differ by exactly one measured-clock period. The sign follows the polarity bit. In this mode a select output asks for doubled integration capacitance. A test selector routes internal signals to two monitor outputs. All widths are counted in oversampling clock cycles.

Top module: `phase_pulse_gen`

## Requirements
- R1: After reset, chg_o and dis_o are low, rst_req_o is high and both monitor outputs are low with test_i=00.
- R2: When the active data edge is sampled while ref_clk_i is low, chg_o goes high for exactly as many clk_i cycles as separate that edge from the next ref_clk_i rising edge, and dis_o stays low.
- R3: When the active data edge is sampled while ref_clk_i is high, dis_o goes high for exactly as many clk_i cycles as separate the preceding ref_clk_i rising edge from that edge, and chg_o stays low. An edge sampled together with a rising edge yields no pulse.
- R4: polar_i=0 makes the falling edge of data_i the active edge and polar_i=1 makes the rising edge active. An edge of the other direction produces no pulse. The polarity is captured when start_ni falls.
- R5: Once one conversion has finished, further data edges produce no pulse until start_ni rises and falls again.
- R6: rst_req_o is high in the cycle after start_ni is sampled high and low while start_ni is sampled low. Raising start_ni ends any pulse in progress.
- R7: With gmes_i=1 captured at arming, data_i is ignored. At the first ref_clk_i rise both pulses start. One pulse lasts one ref_clk_i period and the other lasts two. The longer one is dis_o for polar_i=0 (-0.5T) and chg_o for polar_i=1 (+0.5T).
- R8: cap_dbl_o is high exactly when gmes_i is high.
- R9: test_i=01 drives chg_o on mon_a_o and dis_o on mon_b_o. test_i=10 drives the sampled ref_clk_i on mon_a_o and the sampled data_i on mon_b_o. test_i=00 or 11 holds both monitor outputs low.
- R10: Outside calibration mode, chg_o and dis_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Measured clock |
| data_i | input | 1 | Two-level data signal |
| start_ni | input | 1 | Arm strobe, active low |
| polar_i | input | 1 | Active edge and calibration sign select |
| gmes_i | input | 1 | Calibration mode enable |
| test_i | input | 2 | Monitor routing select |
| chg_o | output | 1 | Charge pulse |
| dis_o | output | 1 | Discharge pulse |
| rst_req_o | output | 1 | Return-to-reference request |
| cap_dbl_o | output | 1 | Doubled integration capacitance select |
| mon_a_o | output | 1 | Monitor output A |
| mon_b_o | output | 1 | Monitor output B |

## Verification
The assertions assume that ref_clk_i, data_i and start_ni are already synchronous to clk_i. They also assume that start_ni stays low for at least one ref_clk_i period before the data edge being measured. An earlier edge would legitimately become the target, so the polarity checks on pulse onset would be meaningless. The stimulus changes every input on the falling edge of clk_i and drops the strobe in mid-period. It then places the data edge in the second following ref_clk_i period, which leaves at least twelve clk_i cycles of setup.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CHG,
    ST_DIS,
    ST_G_BOTH,
    ST_G_ONE,
    ST_DONE
  } meas_st_e;

  localparam logic [1:0] TST_PULSE = 2'b01;
  localparam logic [1:0] TST_INPUT = 2'b10;
endpackage

// File: rtl/pp_edge_det.sv
module pp_edge_det #(
  parameter int unsigned NCH = 3,
  parameter logic [NCH-1:0] RST_VAL = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] sig_i,
  output logic [NCH-1:0] cur_o,
  output logic [NCH-1:0] rise_o,
  output logic [NCH-1:0] fall_o
);
  logic [NCH-1:0] s1_q, s2_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= RST_VAL[g];
        s2_q[g] <= RST_VAL[g];
      end else begin
        s1_q[g] <= sig_i[g];
        s2_q[g] <= s1_q[g];
      end
    end
    assign rise_o[g] = s1_q[g] & ~s2_q[g];
    assign fall_o[g] = ~s1_q[g] & s2_q[g];
  end

  assign cur_o = s1_q;
endmodule

// File: rtl/pp_meas.sv
module pp_meas
  import pp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_s_i,
  input  logic ref_rise_i,
  input  logic data_rise_i,
  input  logic data_fall_i,
  input  logic start_s_i,
  input  logic start_fall_i,
  input  logic polar_i,
  input  logic gmes_i,
  output logic chg_o,
  output logic dis_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  meas_st_e st_q, st_d;
  logic pol_q, gmes_q;
  logic [CNT_W-1:0] since_q, rem_q, rem_d;
  logic data_edge;

  assign data_edge = pol_q ? data_rise_i : data_fall_i;

  // cycles since last ref rise, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_q <= CNT_ONE;
    else if (ref_rise_i)      since_q <= CNT_ONE;
    else if (since_q != CNT_MAX) since_q <= since_q + CNT_ONE;
  end

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    if (start_s_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:   if (start_fall_i) st_d = ST_ARMED;
        ST_ARMED: begin
          if (gmes_q) begin
            if (ref_rise_i) st_d = ST_G_BOTH;
          end else if (data_edge) begin
            if (ref_rise_i)   st_d = ST_DONE;
            else if (ref_s_i) begin
              st_d  = ST_DIS;
              rem_d = since_q;
            end else          st_d = ST_CHG;
          end
        end
        ST_CHG:    if (ref_rise_i) st_d = ST_DONE;
        ST_DIS: begin
          if (rem_q <= CNT_ONE) st_d = ST_DONE;
          else                  rem_d = rem_q - CNT_ONE;
        end
        ST_G_BOTH: if (ref_rise_i) st_d = ST_G_ONE;
        ST_G_ONE:  if (ref_rise_i) st_d = ST_DONE;
        ST_DONE:   st_d = ST_DONE;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      pol_q  <= 1'b0;
      gmes_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      if (st_q == ST_IDLE && start_fall_i && !start_s_i) begin
        pol_q  <= polar_i;
        gmes_q <= gmes_i;
      end
    end
  end

  assign chg_o = (st_q == ST_CHG) || (st_q == ST_G_BOTH) || (st_q == ST_G_ONE && pol_q);
  assign dis_o = (st_q == ST_DIS) || (st_q == ST_G_BOTH) || (st_q == ST_G_ONE && !pol_q);

  // R10
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gmes_q |-> !(chg_o && dis_o));

  // R2
  lead_onset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(chg_o) && !gmes_q) |-> !$past(ref_s_i));

  // R3
  lag_onset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dis_o) && !gmes_q) |-> $past(ref_s_i));

  // R6
  start_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_s_i |=> (!chg_o && !dis_o));

  // R5
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE && !start_s_i) |=> (!chg_o && !dis_o));
endmodule

// File: rtl/pp_test_mux.sv
module pp_test_mux
  import pp_pkg::*;
(
  input  logic [1:0] test_i,
  input  logic       chg_i,
  input  logic       dis_i,
  input  logic       ref_s_i,
  input  logic       data_s_i,
  output logic       mon_a_o,
  output logic       mon_b_o
);
  always_comb begin
    unique case (test_i)
      TST_PULSE: begin mon_a_o = chg_i;   mon_b_o = dis_i;    end
      TST_INPUT: begin mon_a_o = ref_s_i; mon_b_o = data_s_i; end
      default:   begin mon_a_o = 1'b0;    mon_b_o = 1'b0;     end
    endcase
  end
endmodule

// File: rtl/phase_pulse_gen.sv
module phase_pulse_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_clk_i,
  input  logic       data_i,
  input  logic       start_ni,
  input  logic       polar_i,
  input  logic       gmes_i,
  input  logic [1:0] test_i,
  output logic       chg_o,
  output logic       dis_o,
  output logic       rst_req_o,
  output logic       cap_dbl_o,
  output logic       mon_a_o,
  output logic       mon_b_o
);
  localparam int unsigned NCH = 3;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_DAT = 1;
  localparam int unsigned CH_STR = 2;
  localparam logic [NCH-1:0] RST_VAL = NCH'(1) << CH_STR;

  logic [NCH-1:0] cur, rise, fall;
  logic chg, dis;

  pp_edge_det #(.NCH(NCH), .RST_VAL(RST_VAL)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({start_ni, data_i, ref_clk_i}),
    .cur_o  (cur),
    .rise_o (rise),
    .fall_o (fall)
  );

  pp_meas #(.CNT_W(CNT_W)) i_meas (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ref_s_i      (cur[CH_REF]),
    .ref_rise_i   (rise[CH_REF]),
    .data_rise_i  (rise[CH_DAT]),
    .data_fall_i  (fall[CH_DAT]),
    .start_s_i    (cur[CH_STR]),
    .start_fall_i (fall[CH_STR]),
    .polar_i      (polar_i),
    .gmes_i       (gmes_i),
    .chg_o        (chg),
    .dis_o        (dis)
  );

  pp_test_mux i_mux (
    .test_i   (test_i),
    .chg_i    (chg),
    .dis_i    (dis),
    .ref_s_i  (cur[CH_REF]),
    .data_s_i (cur[CH_DAT]),
    .mon_a_o  (mon_a_o),
    .mon_b_o  (mon_b_o)
  );

  assign chg_o     = chg;
  assign dis_o     = dis;
  assign rst_req_o = cur[CH_STR];
  assign cap_dbl_o = gmes_i;
endmodule

// File: tb/test_phase_pulse_gen.sv
module test_phase_pulse_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_clk = 1'b0, data = 1'b0, start_n = 1'b1, polar = 1'b0, gmes = 1'b0;
  logic [1:0] test = 2'b00;
  logic chg, dis, rst_req, cap_dbl, mon_a, mon_b;

  int n_chk = 0, n_bad = 0;
  int ph = 7;
  bit freeze = 1'b0, en = 1'b0;
  int c_chg, c_dis, c_ma, c_mb;

  // {gmes, polar, offset, exp_chg, exp_dis}; ref period 8 clk, high for phases 0..3
  typedef struct packed {
    logic gm; logic pol; logic [3:0] off; logic [4:0] ec; logic [4:0] ed;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'd5, 5'd3,  5'd0},
    '{1'b0, 1'b1, 4'd6, 5'd2,  5'd0},
    '{1'b0, 1'b0, 4'd2, 5'd0,  5'd2},
    '{1'b0, 1'b1, 4'd3, 5'd0,  5'd3},
    '{1'b0, 1'b1, 4'd1, 5'd0,  5'd1},
    '{1'b0, 1'b0, 4'd7, 5'd1,  5'd0},
    '{1'b0, 1'b1, 4'd4, 5'd4,  5'd0},
    '{1'b0, 1'b0, 4'd0, 5'd0,  5'd0},
    '{1'b1, 1'b0, 4'd5, 5'd8,  5'd16},
    '{1'b1, 1'b1, 4'd2, 5'd16, 5'd8}
  };

  phase_pulse_gen i_phase_pulse_gen (
    .clk_i(clk), .rst_ni(rst_ni), .ref_clk_i(ref_clk), .data_i(data),
    .start_ni(start_n), .polar_i(polar), .gmes_i(gmes), .test_i(test),
    .chg_o(chg), .dis_o(dis), .rst_req_o(rst_req), .cap_dbl_o(cap_dbl),
    .mon_a_o(mon_a), .mon_b_o(mon_b)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (en) begin
      c_chg += int'(chg); c_dis += int'(dis);
      c_ma += int'(mon_a); c_mb += int'(mon_b);
    end
    if (!freeze) begin
      ph = (ph + 1) % 8;
      ref_clk = (ph < 4);
    end
  endtask

  task automatic tick_to(input int p);
    do tick(); while (ph != p);
  endtask

  task automatic run_vec(input vec_t v);
    test = 2'b01; gmes = v.gm; polar = v.pol; data = ~v.pol; start_n = 1'b1;
    repeat (16) tick();
    tick_to(4);
    start_n = 1'b0;
    c_chg = 0; c_dis = 0; c_ma = 0; c_mb = 0; en = 1'b1;
    tick_to(0);
    tick_to(0);
    if (v.off != 0) tick_to(int'(v.off));
    data = v.pol;
    tick_to(0);
    tick_to(2);
    data = ~v.pol;
    tick_to(5);
    data = v.pol; // second active edge must be ignored (R5)
    repeat (24) tick();
    en = 1'b0;
    check(v.gm ? "R7 chg width" : "R2 R5 chg width", c_chg, int'(v.ec));
    check(v.gm ? "R7 dis width" : "R3 R5 dis width", c_dis, int'(v.ed));
    check("R9 mon_a follows chg", c_ma, int'(v.ec));
    check("R9 mon_b follows dis", c_mb, int'(v.ed));
    check("R6 rst_req low while armed", int'(rst_req), 0);
    check("R8 cap_dbl", int'(cap_dbl), int'(v.gm));
    start_n = 1'b1;
    tick(); tick();
    check("R6 rst_req after start high", int'(rst_req), 1);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) tick();
    check("R1 chg reset", int'(chg), 0);
    check("R1 dis reset", int'(dis), 0);
    check("R1 rst_req reset", int'(rst_req), 1);
    check("R1 mon_a reset", int'(mon_a), 0);
    check("R1 mon_b reset", int'(mon_b), 0);
    rst_ni = 1'b1;
    repeat (4) tick();

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R4: inactive edge direction yields no pulse
    test = 2'b01; gmes = 1'b0; polar = 1'b0; data = 1'b0;
    repeat (8) tick();
    tick_to(4);
    start_n = 1'b0; c_chg = 0; c_dis = 0; c_ma = 0; c_mb = 0; en = 1'b1;
    tick_to(0); tick_to(6);
    data = 1'b1;
    repeat (24) tick();
    en = 1'b0;
    check("R4 no chg on rising edge with polar0", c_chg, 0);
    check("R4 no dis on rising edge with polar0", c_dis, 0);
    start_n = 1'b1;
    tick(); tick();

    // R9 input routing and idle codes
    freeze = 1'b1;
    test = 2'b10; ref_clk = 1'b1; data = 1'b0;
    tick(); tick();
    check("R9 test10 mon_a=ref", int'(mon_a), 1);
    check("R9 test10 mon_b=data", int'(mon_b), 0);
    ref_clk = 1'b0; data = 1'b1;
    tick(); tick();
    check("R9 test10 mon_a=ref", int'(mon_a), 0);
    check("R9 test10 mon_b=data", int'(mon_b), 1);
    ref_clk = 1'b1;
    test = 2'b00;
    tick(); tick();
    check("R9 test00 mon_a low", int'(mon_a), 0);
    check("R9 test00 mon_b low", int'(mon_b), 0);
    test = 2'b11;
    tick();
    check("R9 test11 mon_b low", int'(mon_b), 0);
    gmes = 1'b1;
    tick();
    check("R8 cap_dbl high", int'(cap_dbl), 1);
    gmes = 1'b0;
    tick();
    check("R8 cap_dbl low", int'(cap_dbl), 0);

    finish_up();
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end
endmodule